// File: doc/BRIEF.md
# Planar video memory write unit

This unit turns one CPU byte store into the video-memory window into a single write on a four-plane memory port. That port is 32 bits wide, with one byte lane per plane. With each request the caller supplies the byte address inside the window, the data byte, a snapshot of the graphics and sequencer control fields, and the current 32-bit latch word.

The unit first decodes the address against the selected window. It then takes one of three paths:
- **Chain-4:** the target plane comes from the address.
- **Odd/even:** the target plane comes from the address together with a page-select bit.
- **Planar:** one of four write modes runs. The data byte can be rotated, replaced by the set/reset value or expanded into colours. The result is then combined with the latch, merged under the bit mask and gated by the map mask.

Requests use a valid/ready handshake. The memory write appears in the cycle after acceptance. The unit takes no new request during that cycle.

Top module: `vga_plane_writer`

## Requirements
- R1: `req_ready` is high after reset and whenever the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its result is on the memory port in the next cycle. `req_ready` is low for exactly that one cycle. A request held valid during that cycle is not taken.
- R2: `map_mode` selects the window.
  - 0: the whole 128 KiB, offset = address.
  - 1: addresses below 0x10000, offset = address.
  - 2: addresses 0x10000 to 0x17FFF, offset = address − 0x10000.
  - 3: addresses 0x18000 to 0x1FFFF, offset = address − 0x18000.
  Addresses outside the window give no memory write (`mem_we` stays 0).
- R3: When `chain4_en` is 1, the plane p is offset bits [1:0] and the word address is offset >> 2. The data byte is put on every lane. `mem_be` is the one-hot (1 << p) when `map_mask` bit p is 1. Otherwise no write occurs.
- R4: When `chain4_en` is 0 and `oddeven_en` is 1, the plane is p = {`oddeven_hi`, offset bit 0} and the word address is offset >> 1. Data, byte enable and gating follow the same rules as R3.
- R5: In planar mode (both path selects 0), write mode (`write_mode`) 0 rotates the data byte right by `rot_count` and copies it to all planes. Each plane p with `setreset_en` bit p set is replaced by 0xFF or 0x00, following `setreset_val` bit p. The bit mask is `bit_mask`.
- R6: Planar write mode 1 writes the latch word unchanged, with no logic operation and no bit mask.
- R7: Planar write mode 2 makes plane p 0xFF if data bit p is 1, and 0x00 otherwise. The bit mask is `bit_mask`.
- R8: In planar write mode 3, plane p is the value expanded from `setreset_val` bit p. The bit mask is the rotated data byte ANDed with `bit_mask`.
- R9: In planar modes 0, 2 and 3, the value is combined with the latch according to `logic_op`: 0 passes it through, 1 ANDs, 2 ORs and 3 XORs.
- R10: After the logic operation, each bit set in the bit mask (applied alike to every plane) is taken from the computed value. Every other bit is taken from the latch.
- R11: In planar mode the planar word address is the offset and `mem_be` equals `map_mask`. A write with `map_mask` 0 is not issued. `chain4_en` takes priority over `oddeven_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | 17 | Byte address inside the 128 KiB video window |
| req_data | input | 8 | CPU data byte |
| map_mode | input | 2 | Window selection (R2) |
| chain4_en | input | 1 | Chain-4 single-plane path |
| oddeven_en | input | 1 | Odd/even single-plane path |
| oddeven_hi | input | 1 | Upper plane-select bit for odd/even |
| write_mode | input | 2 | Planar write mode 0..3 |
| rot_count | input | 3 | Right-rotate amount for the data byte |
| logic_op | input | 2 | Latch combine: pass, AND, OR, XOR |
| setreset_val | input | 4 | Per-plane set/reset value |
| setreset_en | input | 4 | Per-plane set/reset enable (mode 0) |
| bit_mask | input | 8 | Bit mask |
| map_mask | input | 4 | Plane write enables |
| latch | input | 32 | Current latch word, plane p in bits [8p+7:8p] |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 17 | Memory word address |
| mem_be | output | 4 | Per-plane byte enables |
| mem_wdata | output | 32 | Memory write word |

## Verification
Every value in this unit is sampled at acceptance, and the only state held afterwards is the busy flag. Because of that, a wrong busy flag shows at `req_ready` or `mem_we` in the very next cycle. A wrong datapath stage shows in the `mem_wdata`, `mem_be` or `mem_addr` of that same request's write, one cycle after it is accepted. Dropped writes and empty enable masks show as a missing `mem_we` in that cycle. The cycle model in the bench is compared against every one of these outputs on every clock.

// File: rtl/vgaw_pkg.sv
package vgaw_pkg;
  localparam int PLANES = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = PLANES * BYTE_W;

  typedef logic [WORD_W-1:0] word_t;

  // Rotate a byte right by n positions.
  function automatic logic [BYTE_W-1:0] rotr_byte(input logic [BYTE_W-1:0] b,
                                                  input logic [2:0] n);
    logic [2*BYTE_W-1:0] twice;
    twice = {b, b} >> n;
    return twice[BYTE_W-1:0];
  endfunction

  // Copy one byte into every plane lane.
  function automatic word_t repl_byte(input logic [BYTE_W-1:0] b);
    return {PLANES{b}};
  endfunction

  // Each bit of a plane vector becomes a full 0x00/0xFF lane.
  function automatic word_t expand_planes(input logic [PLANES-1:0] n);
    word_t w;
    for (int p = 0; p < PLANES; p++) w[p*BYTE_W +: BYTE_W] = {BYTE_W{n[p]}};
    return w;
  endfunction

  // Combine a value with the latch: 0 pass, 1 and, 2 or, 3 xor.
  function automatic word_t latch_op(input word_t v, input word_t l,
                                     input logic [1:0] op);
    case (op)
      2'd1:    return v & l;
      2'd2:    return v | l;
      2'd3:    return v ^ l;
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/vgaw_window.sv
module vgaw_window #(
  parameter int WIN_W = 17
) (
  input  logic [WIN_W-1:0] addr,
  input  logic [1:0]       map_mode,
  output logic             hit,
  output logic [WIN_W-1:0] offset
);
  always_comb begin
    case (map_mode)
      2'd0: begin
        hit    = 1'b1;
        offset = addr;
      end
      2'd1: begin
        hit    = ~addr[WIN_W-1];
        offset = addr;
      end
      2'd2: begin
        hit    = (addr[WIN_W-1:WIN_W-2] == 2'b10);
        offset = {2'b00, addr[WIN_W-3:0]};
      end
      default: begin
        hit    = (addr[WIN_W-1:WIN_W-2] == 2'b11);
        offset = {2'b00, addr[WIN_W-3:0]};
      end
    endcase
  end
endmodule

// File: rtl/vgaw_single.sv
module vgaw_single
  import vgaw_pkg::*;
#(
  parameter int WIN_W = 17
) (
  input  logic [WIN_W-1:0]  offset,
  input  logic              chain4,
  input  logic              oe_hi,
  input  logic [BYTE_W-1:0] data,
  input  logic [PLANES-1:0] map_mask,
  output logic [WIN_W-1:0]  word_addr,
  output logic [PLANES-1:0] be,
  output word_t             wdata
);
  logic [1:0] lane;

  always_comb begin
    if (chain4) begin
      lane      = offset[1:0];
      word_addr = offset >> 2;
    end else begin
      lane      = {oe_hi, offset[0]};
      word_addr = offset >> 1;
    end
    be    = map_mask[lane] ? (PLANES'(1) << lane) : '0;
    wdata = repl_byte(data);
  end
endmodule

// File: rtl/vgaw_planar.sv
module vgaw_planar
  import vgaw_pkg::*;
(
  input  logic [BYTE_W-1:0] data,
  input  word_t             latch,
  input  logic [1:0]        mode,
  input  logic [2:0]        rot,
  input  logic [1:0]        op,
  input  logic [PLANES-1:0] sr_val,
  input  logic [PLANES-1:0] sr_en,
  input  logic [BYTE_W-1:0] bit_mask,
  output word_t             word
);
  logic [BYTE_W-1:0] rot_byte;
  logic [BYTE_W-1:0] mask_byte;
  word_t             src_val;
  word_t             op_val;
  word_t             mask_word;

  assign rot_byte = rotr_byte(data, rot);

  always_comb begin
    case (mode)
      2'd0: begin
        src_val   = (repl_byte(rot_byte) & ~expand_planes(sr_en)) |
                    (expand_planes(sr_val) & expand_planes(sr_en));
        mask_byte = bit_mask;
      end
      2'd2: begin
        src_val   = expand_planes(data[PLANES-1:0]);
        mask_byte = bit_mask;
      end
      2'd3: begin
        src_val   = expand_planes(sr_val);
        mask_byte = bit_mask & rot_byte;
      end
      default: begin
        // An empty mask makes the merge return the latch as it is.
        src_val   = latch;
        mask_byte = '0;
      end
    endcase
  end

  assign op_val    = latch_op(src_val, latch, op);
  assign mask_word = repl_byte(mask_byte);
  assign word      = (op_val & mask_word) | (latch & ~mask_word);
endmodule

// File: rtl/vga_plane_writer.sv
module vga_plane_writer
  import vgaw_pkg::*;
#(
  parameter int WIN_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WIN_W-1:0]  req_addr,
  input  logic [BYTE_W-1:0] req_data,
  input  logic [1:0]        map_mode,
  input  logic              chain4_en,
  input  logic              oddeven_en,
  input  logic              oddeven_hi,
  input  logic [1:0]        write_mode,
  input  logic [2:0]        rot_count,
  input  logic [1:0]        logic_op,
  input  logic [PLANES-1:0] setreset_val,
  input  logic [PLANES-1:0] setreset_en,
  input  logic [BYTE_W-1:0] bit_mask,
  input  logic [PLANES-1:0] map_mask,
  input  logic [WORD_W-1:0] latch,
  output logic              mem_we,
  output logic [WIN_W-1:0]  mem_addr,
  output logic [PLANES-1:0] mem_be,
  output logic [WORD_W-1:0] mem_wdata
);
  logic              win_hit;
  logic [WIN_W-1:0]  win_off;
  logic              single_path;
  logic [WIN_W-1:0]  sp_addr;
  logic [PLANES-1:0] sp_be;
  word_t             sp_data;
  word_t             pl_data;
  logic [WIN_W-1:0]  nx_addr;
  logic [PLANES-1:0] nx_be;
  word_t             nx_data;
  logic              nx_we;
  logic              accept;
  logic              busy;

  vgaw_window #(.WIN_W(WIN_W)) u_window (
    .addr     (req_addr),
    .map_mode (map_mode),
    .hit      (win_hit),
    .offset   (win_off)
  );

  vgaw_single #(.WIN_W(WIN_W)) u_single (
    .offset    (win_off),
    .chain4    (chain4_en),
    .oe_hi     (oddeven_hi),
    .data      (req_data),
    .map_mask  (map_mask),
    .word_addr (sp_addr),
    .be        (sp_be),
    .wdata     (sp_data)
  );

  vgaw_planar u_planar (
    .data     (req_data),
    .latch    (latch),
    .mode     (write_mode),
    .rot      (rot_count),
    .op       (logic_op),
    .sr_val   (setreset_val),
    .sr_en    (setreset_en),
    .bit_mask (bit_mask),
    .word     (pl_data)
  );

  assign single_path = chain4_en | oddeven_en;
  assign nx_addr     = single_path ? sp_addr : win_off;
  assign nx_be       = single_path ? sp_be   : map_mask;
  assign nx_data     = single_path ? sp_data : pl_data;
  assign nx_we       = win_hit & (|nx_be);
  assign accept      = req_valid & req_ready;
  assign req_ready   = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mem_we <= 1'b0;
    end else begin
      busy   <= accept;
      mem_we <= accept & nx_we;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mem_addr  <= nx_addr;
      mem_be    <= nx_be;
      mem_wdata <= nx_data;
    end
  end

  // R1: the unit is busy for exactly one cycle per request
  p_busy_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R1: every write is the result of the request taken one edge earlier
  p_we_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(accept) && !req_ready));

  // R11: byte enables never exceed the map mask given with the request
  p_be_in_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_be & ~$past(map_mask)) == '0));

  // R3: a single-plane write touches exactly one lane
  p_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(chain4_en || oddeven_en)) |-> ($countones(mem_be) == 1));

  // R6: write mode 1 stores the latch unchanged
  p_latch_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(!chain4_en && !oddeven_en && write_mode == 2'd1))
      |-> (mem_wdata == $past(latch)));

  // R2: the two small windows produce addresses inside their 32 KiB span
  p_small_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(map_mode[1])) |-> (mem_addr[WIN_W-1:WIN_W-2] == 2'b00));
endmodule

// File: tb/vga_plane_writer_test.sv
`timescale 1ns/1ps
module vga_plane_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  dat = '0;
  logic [1:0]  mmode = '0;
  logic        c4 = 1'b0, oe = 1'b0, ohi = 1'b0;
  logic [1:0]  wmode = '0, op = '0;
  logic [2:0]  rot = '0;
  logic [3:0]  srv = '0, sren = '0, mmask = '0;
  logic [7:0]  bmask = '0;
  logic [31:0] lat = '0;
  logic        rdy, we;
  logic [16:0] maddr;
  logic [3:0]  mbe;
  logic [31:0] mdata;

  int errors = 0;
  int checks = 0;
  bit pend = 0;
  bit e_we;
  logic [16:0] e_addr;
  logic [3:0]  e_be;
  logic [31:0] e_data;
  string e_tag = "R1";

  always #4 clk = ~clk;

  vga_plane_writer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_ready(rdy),
    .req_addr(addr), .req_data(dat), .map_mode(mmode), .chain4_en(c4),
    .oddeven_en(oe), .oddeven_hi(ohi), .write_mode(wmode), .rot_count(rot),
    .logic_op(op), .setreset_val(srv), .setreset_en(sren), .bit_mask(bmask),
    .map_mask(mmask), .latch(lat), .mem_we(we), .mem_addr(maddr),
    .mem_be(mbe), .mem_wdata(mdata)
  );

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural model of one request, from the requirement text.
  task automatic model();
    int a, off, plane, r;
    bit hit;
    a = int'(addr);
    off = a;
    case (mmode)
      2'd0: hit = 1;
      2'd1: hit = (a < 'h10000);
      2'd2: begin hit = (a >= 'h10000 && a < 'h18000); off = a - 'h10000; end
      default: begin hit = (a >= 'h18000); off = a - 'h18000; end
    endcase
    e_data = '0;
    if (c4 || oe) begin
      if (c4) begin plane = off % 4; e_addr = 17'(off / 4); e_tag = "R3"; end
      else begin plane = (ohi ? 2 : 0) + off % 2; e_addr = 17'(off / 2); e_tag = "R4"; end
      e_be = mmask[plane] ? 4'(1 << plane) : 4'd0;
      for (int p = 0; p < 4; p++) e_data[p*8 +: 8] = dat;
    end else begin
      e_addr = 17'(off);
      e_be = mmask;
      r = ((int'(dat) >> rot) | (int'(dat) << (8 - rot))) & 255;
      case (wmode)
        2'd0: e_tag = "R5/R9/R10/R11";
        2'd1: e_tag = "R6/R11";
        2'd2: e_tag = "R7/R9/R10/R11";
        default: e_tag = "R8/R9/R10/R11";
      endcase
      for (int p = 0; p < 4; p++)
        for (int b = 0; b < 8; b++) begin
          bit l, v, m, res;
          l = lat[p*8 + b];
          m = bmask[b];
          case (wmode)
            2'd0: v = sren[p] ? srv[p] : r[b];
            2'd2: v = dat[p];
            2'd3: begin v = srv[p]; m = bmask[b] & r[b]; end
            default: v = l;
          endcase
          case (op)
            2'd1: v = v & l;
            2'd2: v = v | l;
            2'd3: v = v ^ l;
            default: ;
          endcase
          res = (wmode == 2'd1) ? l : (m ? v : l);
          e_data[p*8 + b] = res;
        end
    end
    if (!hit) e_tag = "R2";
    e_we = hit && (e_be != 0);
  endtask

  // One clock: apply what the previous posedge did, then compare.
  task automatic step();
    bit acc;
    @(negedge clk);
    acc = vld && !pend;
    if (acc) model();
    pend = acc;
    chk(rdy == !pend, "R1", "req_ready", 32'(rdy), 32'(!pend));
    if (pend) begin
      chk(we == e_we, e_tag, "mem_we", 32'(we), 32'(e_we));
      if (e_we && we) begin
        chk(maddr == e_addr, e_tag, "mem_addr", 32'(maddr), 32'(e_addr));
        chk(mbe == e_be, e_tag, "mem_be", 32'(mbe), 32'(e_be));
        chk(mdata == e_data, e_tag, "mem_wdata", mdata, e_data);
      end
    end else begin
      chk(we == 1'b0, "R1", "idle mem_we", 32'(we), 32'd0);
    end
  endtask

  // Hold valid over the busy cycle too: the second edge must not take it.
  task automatic issue();
    vld = 1'b1;
    step();
    step();
    vld = 1'b0;
  endtask

  task automatic planar(logic [1:0] m, logic [1:0] o, logic [7:0] d, logic [7:0] bm,
                        logic [31:0] l);
    c4 = 0; oe = 0; mmode = 0; addr = 17'h00123; mmask = 4'hF;
    wmode = m; op = o; dat = d; bmask = bm; lat = l;
    issue();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R1", "reset req_ready", 32'(rdy), 32'd1);
    chk(we == 1'b0, "R1", "reset mem_we", 32'(we), 32'd0);
    rst_n = 1'b1;
    step();

    // R2 window edges
    mmask = 4'hF; dat = 8'h5A; c4 = 1;
    mmode = 1; addr = 17'h0FFFF; issue();
    mmode = 1; addr = 17'h10000; issue();
    mmode = 2; addr = 17'h10000; issue();
    mmode = 2; addr = 17'h17FFF; issue();
    mmode = 2; addr = 17'h18000; issue();
    mmode = 3; addr = 17'h18000; issue();
    mmode = 3; addr = 17'h17FFF; issue();
    mmode = 0; addr = 17'h1FFFF; issue();

    // R3 chain-4 lanes and gating
    mmode = 0;
    for (int i = 0; i < 4; i++) begin addr = 17'(16'h0400 + i); mmask = 4'b0101; issue(); end
    // R4 odd/even, chain-4 off; also chain-4 priority (R11)
    c4 = 0; oe = 1; mmask = 4'hF;
    for (int i = 0; i < 4; i++) begin addr = 17'(17'h00200 + i % 2); ohi = i[1]; issue(); end
    mmask = 4'b0010; ohi = 0; addr = 17'h00200; issue();
    c4 = 1; addr = 17'h00203; mmask = 4'hF; issue();
    c4 = 0; oe = 0;

    // R5..R10 planar modes with each logic op
    rot = 3; srv = 4'b1010; sren = 4'b0110;
    for (int m = 0; m < 4; m++)
      for (int o = 0; o < 4; o++)
        planar(2'(m), 2'(o), 8'hC5, 8'h3C, 32'h96A5_0FF0);
    // R10 full and empty bit mask, R11 map mask subsets
    planar(2'd0, 2'd0, 8'h81, 8'hFF, 32'h1234_5678);
    planar(2'd2, 2'd3, 8'h0B, 8'h00, 32'hDEAD_BEEF);
    mmask = 4'b1001; wmode = 0; issue();
    mmask = 4'b0000; issue();

    // Random mix with random valid
    for (int i = 0; i < 600; i++) begin
      vld = $urandom_range(0, 1) == 1;
      addr = 17'($urandom); dat = 8'($urandom); mmode = 2'($urandom);
      c4 = ($urandom_range(0, 3) == 0); oe = ($urandom_range(0, 2) == 0);
      ohi = 1'($urandom); wmode = 2'($urandom); rot = 3'($urandom);
      op = 2'($urandom); srv = 4'($urandom); sren = 4'($urandom);
      bmask = 8'($urandom); mmask = 4'($urandom); lat = $urandom;
      step();
    end
    vld = 0;
    step();
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule